// File: doc/BRIEF.md
# Serial Controller Interrupt Enable and Status Unit

This block collects the event lines of a serial controller (transmit and receive FIFO levels, line errors, overruns, timeouts and modem changes) into one interrupt request. Each event sets a sticky pending bit that stays set until software clears it by writing a one to that bit. A separate mask decides which pending bits may raise the request line.

Software never writes the mask directly. Writing ones to a set port turns mask bits on, and writing ones to a clear port turns them off. This lets several software agents change their own sources without a read-modify-write race. The mask and the pending bits can be read back on a simple single-cycle read/write bus.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset, every mask bit and every pending bit is zero, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write to offset 0x08 (set port) sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x0C (clear port) clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value. Writing 0x1FFF masks every source.
- R4: The mask reads back at offset 0x10, and the pending bits read back at offset 0x14, in bits 12..0 with zeros above. The set and clear ports read as zero. A write to offset 0x10 has no effect.
- R5: Event input bit i sets pending bit i at the next clock edge, whether or not mask bit i is set. The pending bit stays set after the event input returns to 0. Bit order from 12 down to 0: tx overflow, tx nearly full, tx trigger, modem status change, rx timeout, parity error, framing error, rx overflow, tx full, tx empty, rx full, rx empty, rx trigger.
- R6: A write to offset 0x14 clears exactly the pending bits whose write-data bit is 1. Writing 0x1FFF clears all of them. The other pending bits do not change.
- R7: When an event arrives in the same cycle that software clears its pending bit, the bit remains set.
- R8: `irq_o` is registered. In each cycle it equals the OR, over all bits, of pending AND mask as they stood in the previous cycle.
- R9: A read of any address other than 0x10 or 0x14 returns zero. A write to an address other than 0x08, 0x0C or 0x14 changes no state.
- R10: Read data is registered. `rdata_o` holds the register contents as they stood at the clock edge that samples `rd_en_i`. It is zero in any cycle that follows a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (8) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| evt_i | input | N_SRC (13) | Event lines from the datapath, one per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: 13 sources, an 8-bit address and a 32-bit data word. With only 13 sources, it can sweep every one of the 8192 patterns through the set port, the clear port and the pending-clear port. Every partial clear and every mask combination is therefore read back and compared against a bench-side model. Directed sequences cover the case where an event and a clear of the same bit fall in one cycle, writes to the read-only and unused offsets, and the one-cycle lag of the request line.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned SRC_N = 13;

  // source positions; software decodes these
  localparam int unsigned SRC_RX_TRIG   = 0;
  localparam int unsigned SRC_RX_EMPTY  = 1;
  localparam int unsigned SRC_RX_FULL   = 2;
  localparam int unsigned SRC_TX_EMPTY  = 3;
  localparam int unsigned SRC_TX_FULL   = 4;
  localparam int unsigned SRC_RX_OVR    = 5;
  localparam int unsigned SRC_FRAME_ERR = 6;
  localparam int unsigned SRC_PAR_ERR   = 7;
  localparam int unsigned SRC_RX_TOUT   = 8;
  localparam int unsigned SRC_MODEM_CHG = 9;
  localparam int unsigned SRC_TX_TRIG   = 10;
  localparam int unsigned SRC_TX_NFULL  = 11;
  localparam int unsigned SRC_TX_OVR    = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SET,
    SEL_CLR,
    SEL_MASK,
    SEL_PEND
  } reg_sel_e;

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h10,
  parameter logic [ADDR_W-1:0] OFS_PEND = 'h14
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == OFS_SET)       sel_o = SEL_SET;
    else if (addr_i == OFS_CLR)  sel_o = SEL_CLR;
    else if (addr_i == OFS_MASK) sel_o = SEL_MASK;
    else if (addr_i == OFS_PEND) sel_o = SEL_PEND;
  end

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] mask_o
);

  logic [N_SRC-1:0] mask_d;

  // clear dominates when both hit one bit
  assign mask_d = (mask_o | set_i) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= mask_d;
  end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_o[g] <= 1'b0;
      else if (evt_i[g])   pend_o[g] <= 1'b1;  // event beats clear
      else if (clr_i[g])   pend_o[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_N,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h10,
  parameter logic [ADDR_W-1:0] OFS_PEND = 'h14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  evt_i,
  output logic              irq_o
);

  localparam int unsigned PAD_W = DATA_W - N_SRC;

  reg_sel_e         sel;
  logic [N_SRC-1:0] wbits;
  logic [N_SRC-1:0] mask_set, mask_clr, pend_clr;
  logic [N_SRC-1:0] mask_q, stat_q;
  logic [DATA_W-1:0] rd_mux;

  assign wbits = wdata_i[N_SRC-1:0];

  uart_irq_decode #(
    .ADDR_W(ADDR_W), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR),
    .OFS_MASK(OFS_MASK), .OFS_PEND(OFS_PEND)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign mask_set = (wr_en_i && sel == SEL_SET)  ? wbits : '0;
  assign mask_clr = (wr_en_i && sel == SEL_CLR)  ? wbits : '0;
  assign pend_clr = (wr_en_i && sel == SEL_PEND) ? wbits : '0;

  uart_irq_mask #(.N_SRC(N_SRC)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (mask_set),
    .clr_i (mask_clr),
    .mask_o(mask_q)
  );

  uart_irq_status #(.N_SRC(N_SRC)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .clr_i (pend_clr),
    .pend_o(stat_q)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK: rd_mux = {{PAD_W{1'b0}}, mask_q};
      SEL_PEND: rd_mux = {{PAD_W{1'b0}}, stat_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_en_i ? rd_mux : '0;
      irq_o   <= |(stat_q & mask_q);
    end
  end

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int unsigned N_SRC  = 13,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_PEND = 'h14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_SRC-1:0]  evt_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  stat_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (mask_q == '0 && stat_q == '0 && !irq_o));

  // R2
  set_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_SET) |=>
      ((mask_q & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0])));

  // R3
  clr_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_CLR) |=>
      ((mask_q & $past(wdata_i[N_SRC-1:0])) == '0));

  // R5
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R5
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFS_PEND) |=>
      ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == (|($past(stat_q) & $past(mask_q)))));

  // R10
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));

endmodule

bind uart_irq_unit uart_irq_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR), .OFS_PEND(OFS_PEND)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .evt_i  (evt_i),
  .irq_o  (irq_o),
  .mask_q (mask_q),
  .stat_q (stat_q)
);

// File: tb/sim_uart_irq_unit.sv
`timescale 1ns/1ps
module sim_uart_irq_unit;

  localparam logic [7:0] A_SET = 8'h08, A_CLR = 8'h0C, A_MASK = 8'h10, A_PEND = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [12:0] evt = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [12:0] mask_m = '0, stat_m = '0;

  always #2.5 clk = ~clk;

  uart_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == A_MASK) return {19'd0, mask_m};
    if (a == A_PEND) return {19'd0, stat_m};
    return 32'd0;
  endfunction

  // one bus cycle; called and returns at a falling edge
  task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [31:0] d, input logic [12:0] e, input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    wr_en = wr; rd_en = rd; addr = a; wdata = d; evt = e;
    @(posedge clk);
    exp_rd  = rd ? model_read(a) : 32'd0;
    exp_irq = |(stat_m & mask_m);
    if (wr) begin
      if (a == A_SET)  mask_m = mask_m | d[12:0];
      if (a == A_CLR)  mask_m = mask_m & ~d[12:0];
      if (a == A_PEND) stat_m = stat_m & ~d[12:0];
    end
    stat_m = stat_m | e;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt = '0;
    chk(tag, rdata, exp_rd);
    chk("R8", {31'd0, irq}, {31'd0, exp_irq});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, '0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, a, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", rdata, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_MASK, "R1");
    rd(A_PEND, "R1");

    // R5 each source latches alone while masked, stays after event drops
    for (int b = 0; b < 13; b++) begin
      step(1'b0, 1'b0, 8'h00, '0, 13'(1 << b), "R5");
      step(1'b0, 1'b0, 8'h00, '0, '0, "R5");
      rd(A_PEND, "R5");
      chk("R5", {19'd0, stat_m}, 32'(1 << b));
      wr(A_PEND, 32'h1FFF, "R6");
    end

    // R7 event collides with clear of same bit
    step(1'b0, 1'b0, 8'h00, '0, 13'h0088, "R5");
    step(1'b1, 1'b0, A_PEND, 32'h00C8, 13'h0008, "R7");
    rd(A_PEND, "R7");
    chk("R7", {19'd0, stat_m}, 32'h0008);
    wr(A_PEND, 32'h1FFF, "R6");

    // R4 R9 read-only mask, unused offsets, write ports read zero
    wr(A_SET, 32'h0155, "R2");
    wr(A_MASK, 32'h1FFF, "R4");
    rd(A_MASK, "R4");
    wr(8'h00, 32'hFFFF_FFFF, "R9");
    wr(8'h18, 32'hFFFF_FFFF, "R9");
    rd(A_MASK, "R9");
    rd(A_SET, "R4");
    rd(A_CLR, "R4");
    rd(8'h04, "R9");
    rd(8'h30, "R9");

    // R8 request follows pending AND mask by one cycle
    step(1'b0, 1'b0, 8'h00, '0, 13'h0002, "R8");
    step(1'b0, 1'b0, 8'h00, '0, '0, "R8");
    chk("R8", {31'd0, irq}, 32'd0);
    step(1'b0, 1'b0, 8'h00, '0, 13'h0004, "R8");
    step(1'b0, 1'b0, 8'h00, '0, '0, "R8");
    chk("R8", {31'd0, irq}, 32'd1);
    wr(A_CLR, 32'h0004, "R3");
    step(1'b0, 1'b0, 8'h00, '0, '0, "R8");
    chk("R8", {31'd0, irq}, 32'd0);
    wr(A_CLR, 32'h1FFF, "R3");
    wr(A_PEND, 32'h1FFF, "R6");
    rd(A_PEND, "R6");

    // R2 R3 exhaustive mask patterns over a fixed background
    for (int v = 0; v < 8192; v++) begin
      wr(A_SET, 32'h0A5A, "R2");
      wr(A_SET, 32'(v), "R2");
      rd(A_MASK, "R2");
      wr(A_CLR, 32'(v), "R3");
      rd(A_MASK, "R3");
      wr(A_CLR, 32'h1FFF, "R3");
    end

    // R6 exhaustive partial clears of a full pending set, irq enabled
    wr(A_SET, 32'h1FFF, "R2");
    for (int v = 0; v < 8192; v++) begin
      step(1'b0, 1'b0, 8'h00, '0, 13'h1FFF, "R5");
      wr(A_PEND, 32'(v) | 32'hFFFF_E000, "R6");
      rd(A_PEND, "R6");
      chk("R6", {19'd0, stat_m}, 32'(~v & 32'h1FFF));
    end

    // R10 read data lands in the cycle after the read
    step(1'b0, 1'b1, A_PEND, '0, 13'h1000, "R10");
    rd(A_PEND, "R10");
    step(1'b0, 1'b0, 8'h00, '0, '0, "R10");
    chk("R10", rdata, 32'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule